// File: doc/BRIEF.md
# Performance Monitor Register Block

This block is the software-visible control plane of a small performance-monitoring unit. A register bus reaches a global control word, three set/clear register pairs (counter enables, interrupt enables, overflow flags), a counter-select word, indirect type and value windows, a direct cycle-counter window, a software-increment strobe and a read-only capability word. The block also holds the counter storage: `NUM_EVT` event counters, and one cycle counter that always sits at index 31 of every per-counter bit vector.

Each counter's effective enable is the global enable ANDed with that counter's own enable bit. Event counters advance on their qualified event pulse, or on a software-increment write when their event type equals the software-increment code. The cycle counter advances every enabled clock, or once every 64 enabled clocks in divide mode. A counter that wraps past all-ones sets its overflow flag.

A three-state machine drives the level interrupt. In `IRQ_IDLE` the overflow flags are all zero. When the next flags are nonzero, `IRQ_IDLE` moves to `IRQ_RAISED` if some set flag also has its interrupt enable set. Otherwise it moves to `IRQ_SILENT`. From `IRQ_SILENT` and from `IRQ_RAISED` the only transition is back to `IRQ_IDLE`, taken when the next flags are all zero. The output `irq` is high only in `IRQ_RAISED`.

Top module: `pmu_regblk`

## Requirements
- R1: Control register (address 0). A read returns the fixed identity field (implementation code in bits 31:24, `NUM_EVT` in bits 15:11) ORed with the written value masked by 0x39. Bits 1 and 2 always read zero.
- R2: Writing address 0 with bit 1 set zeroes every event counter at that edge. Writing it with bit 2 set zeroes the cycle counter at that edge. Neither write disturbs the other kind of counter.
- R3: `cnt_en[i]` equals control bit 0 AND bit i of the enable register. Bit 31 is the cycle counter. Bits of counters that do not exist are zero.
- R4: Enable pair (set at 1, clear at 2), interrupt-enable pair (3, 4) and overflow pair (5, 6). A set write ORs the data in, and a clear write removes the bits that are one in the data. Both addresses of a pair read the same value. Bits of counters that do not exist stay zero.
- R5: `irq` rises at the edge where the overflow flags go from all-zero to nonzero while some set flag has its interrupt enable set. If the flags were already nonzero with no matching enable, a later interrupt-enable write does not raise `irq`.
- R6: Once high, `irq` stays high through interrupt-enable clears and partial overflow clears. It drops at the edge where the overflow flags become all-zero.
- R7: The software-increment address (7) reads zero. Writing it adds one to every enabled event counter whose data bit is set and whose event type equals 0. Every other counter is unchanged.
- R8: The select register (address 8, bits 4:0) names the counter that the type window (9) and the value window (10) reach. Index 31 is the cycle counter: its type reads 0x11 and ignores writes, and its value can be read and written. An index between `NUM_EVT` and 30 ignores writes and reads zero. Address 11 reads and writes the cycle counter directly.
- R9: The capability register (address 12) ignores writes and reads the low 32 bits of the capability parameter.
- R10: An enabled event counter whose type is not 0 adds one on each clock that its `evt_in` bit is high. A counter at 0xFFFFFFFF wraps to 0 and sets its overflow flag.
- R11: The enabled cycle counter adds one per clock. With control bit 3 set, it adds one per 64 enabled clocks. Any change of bit 3 clears the divide prescaler.
- R12: After reset, every register and counter reads zero apart from the identity field, and `irq` and `cnt_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_in | input | NUM_EVT | Qualified event pulse per event counter |
| cnt_en | output | 32 | Effective enable per counter, with the cycle counter at bit 31 |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational from registered state, so a write shows up on a read after exactly one rising edge. Every bench write spans one edge, negedge to negedge, and every read samples within the same low phase. `cnt_en`, the overflow flags and `irq` update at the same edge as the write or counter wrap that causes them, and the bench samples them at the following negedge. The cycle counter uses registered enables, so it counts the edge of the disabling write as well. Windows that are opened and closed by control writes therefore last the idle count plus one edge, and the expected tick counts in divide mode are computed from that figure.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
    localparam int CYC_IDX = 31;

    typedef enum logic [3:0] {
        A_CTRL   = 4'd0,
        A_EN_SET = 4'd1,
        A_EN_CLR = 4'd2,
        A_IE_SET = 4'd3,
        A_IE_CLR = 4'd4,
        A_OV_SET = 4'd5,
        A_OV_CLR = 4'd6,
        A_SWINC  = 4'd7,
        A_SEL    = 4'd8,
        A_TYPE   = 4'd9,
        A_VALUE  = 4'd10,
        A_CYCLE  = 4'd11,
        A_CAPS   = 4'd12
    } reg_addr_e;

    localparam int CB_EN    = 0;
    localparam int CB_EVRST = 1;
    localparam int CB_CYRST = 2;
    localparam int CB_DIV   = 3;
    localparam logic [31:0] CTRL_WMASK = 32'h0000_0039;

    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_SILENT = 2'd1,
        IRQ_RAISED = 2'd2
    } irq_state_e;
endpackage

// File: rtl/pmu_regs.sv
`timescale 1ns/1ps
module pmu_regs
    import pmu_pkg::*;
#(
    parameter int              NUM_EVT = 4,
    parameter int              EVT_W   = 8,
    parameter logic [7:0]      IMPL_ID = 8'h5A,
    parameter logic [63:0]     CAPS    = 64'h0000_00C3_0000_A5F1,
    parameter logic [EVT_W-1:0] CYC_EVT = 'h11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic [3:0]                      bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic [31:0]                     hw_ovf,
    input  logic [NUM_EVT-1:0][31:0]        evt_vals,
    input  logic [31:0]                     cyc_val,
    output logic [31:0]                     eff_en,
    output logic [31:0]                     ovf_nx,
    output logic [31:0]                     ie_nx,
    output logic [NUM_EVT-1:0][EVT_W-1:0]   evt_type,
    output logic [NUM_EVT-1:0]              ev_wr,
    output logic                            cyc_wr,
    output logic [NUM_EVT-1:0]              swinc_vec,
    output logic                            evt_rst,
    output logic                            cyc_rst,
    output logic                            div_mode,
    output logic                            div_tgl
);
    localparam logic [31:0] VMASK = 32'h8000_0000 | ((32'd1 << NUM_EVT) - 32'd1);
    localparam logic [31:0] IDENT = (32'(IMPL_ID) << 24) | (32'(NUM_EVT) << 11);

    logic [31:0] ctrl_q, en_q, ie_q, ovf_q, en_nx;
    logic [4:0]  sel_q;
    logic [15:0] hot;
    logic        sel_evt, sel_cyc;

    assign hot     = bus_wr ? (16'd1 << bus_addr) : 16'd0;
    assign sel_evt = sel_q < 5'(NUM_EVT);
    assign sel_cyc = sel_q == 5'(CYC_IDX);

    // set/clear pair updates
    always_comb begin
        en_nx = en_q;
        if (hot[A_EN_SET]) en_nx = en_nx | bus_wdata;
        if (hot[A_EN_CLR]) en_nx = en_nx & ~bus_wdata;
        en_nx = en_nx & VMASK;

        ie_nx = ie_q;
        if (hot[A_IE_SET]) ie_nx = ie_nx | bus_wdata;
        if (hot[A_IE_CLR]) ie_nx = ie_nx & ~bus_wdata;
        ie_nx = ie_nx & VMASK;

        ovf_nx = ovf_q;
        if (hot[A_OV_SET]) ovf_nx = ovf_nx | bus_wdata;
        if (hot[A_OV_CLR]) ovf_nx = ovf_nx & ~bus_wdata;
        ovf_nx = (ovf_nx | hw_ovf) & VMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
            ie_q   <= '0;
            ovf_q  <= '0;
            sel_q  <= '0;
        end else begin
            if (hot[A_CTRL]) ctrl_q <= bus_wdata & CTRL_WMASK;
            if (hot[A_SEL])  sel_q  <= bus_wdata[4:0];
            en_q  <= en_nx;
            ie_q  <= ie_nx;
            ovf_q <= ovf_nx;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_type
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    evt_type[gi] <= '0;
                else if (hot[A_TYPE] && sel_q == 5'(gi))
                    evt_type[gi] <= bus_wdata[EVT_W-1:0];
            end
            assign ev_wr[gi] = hot[A_VALUE] && sel_q == 5'(gi);
        end
    endgenerate

    assign eff_en    = ctrl_q[CB_EN] ? en_q : 32'd0;
    assign cyc_wr    = hot[A_CYCLE] || (hot[A_VALUE] && sel_cyc);
    assign swinc_vec = hot[A_SWINC] ? bus_wdata[NUM_EVT-1:0] : '0;
    assign evt_rst   = hot[A_CTRL] && bus_wdata[CB_EVRST];
    assign cyc_rst   = hot[A_CTRL] && bus_wdata[CB_CYRST];
    assign div_mode  = ctrl_q[CB_DIV];
    assign div_tgl   = hot[A_CTRL] && (bus_wdata[CB_DIV] != ctrl_q[CB_DIV]);

    // read mux
    logic [31:0] win_type, win_val;
    always_comb begin
        win_type = '0;
        win_val  = '0;
        if (sel_cyc) begin
            win_type = 32'(CYC_EVT);
            win_val  = cyc_val;
        end else if (sel_evt) begin
            for (int i = 0; i < NUM_EVT; i++) begin
                if (sel_q == 5'(i)) begin
                    win_type = 32'(evt_type[i]);
                    win_val  = evt_vals[i];
                end
            end
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:             bus_rdata = IDENT | ctrl_q;
            A_EN_SET, A_EN_CLR: bus_rdata = en_q;
            A_IE_SET, A_IE_CLR: bus_rdata = ie_q;
            A_OV_SET, A_OV_CLR: bus_rdata = ovf_q;
            A_SEL:              bus_rdata = {27'd0, sel_q};
            A_TYPE:             bus_rdata = win_type;
            A_VALUE:            bus_rdata = win_val;
            A_CYCLE:            bus_rdata = cyc_val;
            A_CAPS:             bus_rdata = CAPS[31:0];
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmu_cnt_bank.sv
`timescale 1ns/1ps
module pmu_cnt_bank
    import pmu_pkg::*;
#(
    parameter int              NUM_EVT  = 4,
    parameter int              EVT_W    = 8,
    parameter logic [EVT_W-1:0] SWINC_ID = '0,
    parameter int              PRE_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [31:0]                   eff_en,
    input  logic [NUM_EVT-1:0]            evt_in,
    input  logic [NUM_EVT-1:0][EVT_W-1:0] evt_type,
    input  logic [NUM_EVT-1:0]            swinc_vec,
    input  logic [NUM_EVT-1:0]            ev_wr,
    input  logic                          cyc_wr,
    input  logic [31:0]                   wr_data,
    input  logic                          evt_rst,
    input  logic                          cyc_rst,
    input  logic                          div_mode,
    input  logic                          div_tgl,
    output logic [NUM_EVT-1:0][31:0]      evt_vals,
    output logic [31:0]                   cyc_val,
    output logic [31:0]                   hw_ovf
);
    logic [NUM_EVT-1:0] evt_ovf;
    logic               cyc_ovf;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_cnt
            logic inc;
            assign inc = eff_en[gi] &&
                         ((evt_type[gi] == SWINC_ID) ? swinc_vec[gi] : evt_in[gi]);
            assign evt_ovf[gi] = inc && !evt_rst && !ev_wr[gi] && (evt_vals[gi] == '1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         evt_vals[gi] <= '0;
                else if (evt_rst)   evt_vals[gi] <= '0;
                else if (ev_wr[gi]) evt_vals[gi] <= wr_data;
                else if (inc)       evt_vals[gi] <= evt_vals[gi] + 32'd1;
            end
        end
    endgenerate

    logic [PRE_W-1:0] pre_q;
    logic             tick;
    assign tick    = eff_en[CYC_IDX] && (!div_mode || pre_q == '1);
    assign cyc_ovf = tick && !cyc_rst && !cyc_wr && (cyc_val == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           pre_q <= '0;
        else if (div_tgl)                     pre_q <= '0;
        else if (eff_en[CYC_IDX] && div_mode) pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cyc_val <= '0;
        else if (cyc_rst) cyc_val <= '0;
        else if (cyc_wr)  cyc_val <= wr_data;
        else if (tick)    cyc_val <= cyc_val + 32'd1;
    end

    always_comb begin
        hw_ovf = '0;
        for (int i = 0; i < NUM_EVT; i++) hw_ovf[i] = evt_ovf[i];
        hw_ovf[CYC_IDX] = cyc_ovf;
    end
endmodule

// File: rtl/pmu_irq_fsm.sv
`timescale 1ns/1ps
module pmu_irq_fsm
    import pmu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ovf_nx,
    input  logic [31:0] ie_nx,
    output logic        irq
);
    irq_state_e st_q, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            IRQ_IDLE:
                if (|ovf_nx) st_nx = (|(ovf_nx & ie_nx)) ? IRQ_RAISED : IRQ_SILENT;
            IRQ_SILENT, IRQ_RAISED:
                if (!(|ovf_nx)) st_nx = IRQ_IDLE;
            default: st_nx = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (st_q == IRQ_RAISED);
    end
endmodule

// File: rtl/pmu_regblk.sv
`timescale 1ns/1ps
module pmu_regblk
    import pmu_pkg::*;
#(
    parameter int              NUM_EVT  = 4,
    parameter int              EVT_W    = 8,
    parameter logic [7:0]      IMPL_ID  = 8'h5A,
    parameter logic [63:0]     CAPS     = 64'h0000_00C3_0000_A5F1,
    parameter logic [EVT_W-1:0] CYC_EVT  = 'h11,
    parameter logic [EVT_W-1:0] SWINC_ID = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [31:0]        cnt_en,
    output logic               irq
);
    logic [31:0]                   hw_ovf, ovf_nx, ie_nx, cyc_val, wr_data;
    logic [NUM_EVT-1:0][31:0]      evt_vals;
    logic [NUM_EVT-1:0][EVT_W-1:0] evt_type;
    logic [NUM_EVT-1:0]            ev_wr, swinc_vec;
    logic                          cyc_wr, evt_rst, cyc_rst, div_mode, div_tgl;

    assign wr_data = bus_wdata;

    pmu_regs #(
        .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .IMPL_ID(IMPL_ID),
        .CAPS(CAPS), .CYC_EVT(CYC_EVT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_ovf(hw_ovf),
        .evt_vals(evt_vals), .cyc_val(cyc_val), .eff_en(cnt_en),
        .ovf_nx(ovf_nx), .ie_nx(ie_nx), .evt_type(evt_type), .ev_wr(ev_wr),
        .cyc_wr(cyc_wr), .swinc_vec(swinc_vec), .evt_rst(evt_rst),
        .cyc_rst(cyc_rst), .div_mode(div_mode), .div_tgl(div_tgl)
    );

    pmu_cnt_bank #(
        .NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .SWINC_ID(SWINC_ID)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .eff_en(cnt_en), .evt_in(evt_in),
        .evt_type(evt_type), .swinc_vec(swinc_vec), .ev_wr(ev_wr),
        .cyc_wr(cyc_wr), .wr_data(wr_data), .evt_rst(evt_rst),
        .cyc_rst(cyc_rst), .div_mode(div_mode), .div_tgl(div_tgl),
        .evt_vals(evt_vals), .cyc_val(cyc_val), .hw_ovf(hw_ovf)
    );

    pmu_irq_fsm u_irq (
        .clk(clk), .rst_n(rst_n), .ovf_nx(ovf_nx), .ie_nx(ie_nx), .irq(irq)
    );
endmodule

// File: rtl/pmu_regblk_chk.sv
`timescale 1ns/1ps
module pmu_regblk_chk
    import pmu_pkg::*;
#(
    parameter logic [63:0] CAPS = 64'h0000_00C3_0000_A5F1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] cnt_en,
    input logic        irq
);
    AST_CTRL_PC_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_CTRL |-> bus_rdata[2:1] == 2'b00); // R1
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && !bus_wdata[CB_EN]) |=> cnt_en == 32'd0); // R3
    AST_EN_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN_CLR) |=> (cnt_en & $past(bus_wdata)) == 32'd0); // R4
    AST_IRQ_FALL_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr && bus_addr == A_OV_CLR)); // R6
    AST_SWINC_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_SWINC |-> bus_rdata == 32'd0); // R7
    AST_CAPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_CAPS |-> bus_rdata == CAPS[31:0]); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!irq && cnt_en == 32'd0)); // R12
endmodule

bind pmu_regblk pmu_regblk_chk #(.CAPS(CAPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en), .irq(irq)
);

// File: tb/sim_pmu_regblk.sv
`timescale 1ns/1ps
module sim_pmu_regblk;
    localparam int          N     = 4;
    localparam logic [31:0] IDENT = 32'h5A00_2000;
    localparam logic [31:0] VM    = 32'h8000_000F;
    localparam logic [31:0] CAPLO = 32'h0000_A5F1;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, cnt_en, rv;
    logic [N-1:0] evt_in = '0;
    logic irq;
    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    pmu_regblk u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .cnt_en(cnt_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one edge per write; called and returns at a negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_val(input int s, output logic [31:0] d);
        wr(4'd8, 32'(s));
        rd(4'd10, d);
    endtask

    task automatic set_val(input int s, input logic [31:0] v);
        wr(4'd8, 32'(s));
        wr(4'd10, v);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_000A;
        pats[2] = 32'h8000_0005; pats[3] = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(4'd0, rv);  chk("R12 ctrl", rv, IDENT);
        rd(4'd1, rv);  chk("R12 en", rv, 0);
        rd(4'd3, rv);  chk("R12 ie", rv, 0);
        rd(4'd5, rv);  chk("R12 ovf", rv, 0);
        rd(4'd8, rv);  chk("R12 sel", rv, 0);
        rd(4'd11, rv); chk("R12 cycle", rv, 0);
        rd(4'd10, rv); chk("R12 value0", rv, 0);
        chk("R12 irq", 32'(irq), 0);
        chk("R12 cnt_en", cnt_en, 0);

        // R1 control sweep
        for (int v = 0; v < 64; v++) begin
            wr(4'd0, 32'(v));
            rd(4'd0, rv);
            chk("R1 ctrl readback", rv, IDENT | (32'(v) & 32'h39));
        end
        wr(4'd0, 0);

        // R4 set/clear pairs
        for (int p = 1; p <= 5; p += 2) begin
            for (int k = 0; k < 4; k++) begin
                wr(4'(p + 1), 32'hFFFF_FFFF);
                wr(4'(p), pats[k]);
                rd(4'(p), rv);     chk("R4 set view", rv, pats[k] & VM);
                rd(4'(p + 1), rv); chk("R4 clr view", rv, pats[k] & VM);
                wr(4'(p + 1), 32'h3);
                rd(4'(p), rv);     chk("R4 after clear", rv, pats[k] & VM & ~32'h3);
            end
            wr(4'(p + 1), 32'hFFFF_FFFF);
        end

        // R3 effective enable
        for (int e = 0; e < 2; e++) begin
            for (int k = 0; k < 4; k++) begin
                wr(4'd0, 32'(e));
                wr(4'd2, 32'hFFFF_FFFF);
                wr(4'd1, pats[k]);
                chk("R3 cnt_en", cnt_en, (e == 1) ? (pats[k] & VM) : 32'd0);
            end
        end
        wr(4'd0, 0);
        wr(4'd2, 32'hFFFF_FFFF);

        // R8 select sweep
        for (int s = 0; s < 32; s++) begin
            wr(4'd8, 32'(s));
            wr(4'd9, 32'h40 + 32'(s));
            wr(4'd10, 32'h1000 + 32'(s));
            rd(4'd8, rv);  chk("R8 sel", rv, 32'(s));
            rd(4'd9, rv);
            chk("R8 type", rv, (s < N) ? 32'h40 + 32'(s) : (s == 31) ? 32'h11 : 32'd0);
            rd(4'd10, rv);
            chk("R8 value", rv, (s < N || s == 31) ? 32'h1000 + 32'(s) : 32'd0);
        end
        rd(4'd11, rv); chk("R8 cycle direct", rv, 32'h101F);

        // R9 capability
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, rv); chk("R9 caps", rv, CAPLO);

        // R10 event counting and wrap
        set_val(0, 0);
        wr(4'd1, 32'h1);
        wr(4'd0, 32'h1);
        evt_in = 4'b0011;
        idle(5);
        evt_in = '0;
        rd_val(0, rv); chk("R10 count", rv, 5);
        rd_val(1, rv); chk("R10 disabled unchanged", rv, 32'h1001);
        set_val(1, 32'hFFFF_FFFE);
        wr(4'd3, 32'h2);
        wr(4'd1, 32'h2);
        evt_in = 4'b0010;
        idle(2);
        evt_in = '0;
        rd_val(1, rv); chk("R10 wrap", rv, 0);
        rd(4'd5, rv);  chk("R10 ovf flag", rv, 32'h2);
        chk("R5 irq raised", 32'(irq), 1);

        // R6 hold until all-zero
        wr(4'd4, 32'hFFFF_FFFF);
        chk("R6 ie clear keeps irq", 32'(irq), 1);
        wr(4'd5, 32'h1);
        wr(4'd6, 32'h2);
        chk("R6 partial clear keeps irq", 32'(irq), 1);
        wr(4'd6, 32'h1);
        chk("R6 irq drops", 32'(irq), 0);

        // R5 no raise when flags already nonzero
        wr(4'd5, 32'h4);
        chk("R5 silent", 32'(irq), 0);
        wr(4'd3, 32'h4);
        chk("R5 late enable no raise", 32'(irq), 0);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd5, 32'h4);
        chk("R5 set write raises", 32'(irq), 1);
        wr(4'd6, 32'h4);
        chk("R6 drop", 32'(irq), 0);
        wr(4'd4, 32'hFFFF_FFFF);

        // R7 software increment
        wr(4'd0, 0);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd8, 2); wr(4'd9, 0); wr(4'd10, 10);
        wr(4'd8, 3); wr(4'd9, 0); wr(4'd10, 20);
        wr(4'd1, 32'h5);
        wr(4'd0, 32'h1);
        wr(4'd7, 32'hF);
        rd(4'd7, rv);  chk("R7 reads zero", rv, 0);
        rd_val(0, rv); chk("R7 non-swinc type", rv, 5);
        rd_val(1, rv); chk("R7 disabled", rv, 0);
        rd_val(2, rv); chk("R7 incremented", rv, 11);
        rd_val(3, rv); chk("R7 disabled swinc", rv, 20);

        // R2 counter resets
        wr(4'd11, 32'h777);
        wr(4'd0, 32'h3);
        rd_val(0, rv); chk("R2 event reset c0", rv, 0);
        rd_val(2, rv); chk("R2 event reset c2", rv, 0);
        rd(4'd11, rv); chk("R2 cycle kept", rv, 32'h777);
        set_val(2, 9);
        wr(4'd0, 32'h4);
        rd(4'd11, rv); chk("R2 cycle reset", rv, 0);
        rd_val(2, rv); chk("R2 event kept", rv, 9);

        // R11 cycle counter
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h4);
        wr(4'd0, 32'h1);
        chk("R11 cnt_en bit31", cnt_en, 32'h8000_0000);
        idle(9);
        wr(4'd0, 0);
        rd(4'd11, rv); chk("R11 plain count", rv, 10);
        wr(4'd0, 32'h4);
        wr(4'd0, 32'h9);
        idle(189);
        wr(4'd0, 32'h8);
        rd(4'd11, rv); chk("R11 divide count", rv, 2);
        wr(4'd0, 0);
        wr(4'd0, 32'h8);
        wr(4'd0, 32'hC);
        wr(4'd0, 32'h9);
        idle(29);
        wr(4'd0, 32'h8);
        rd(4'd11, rv); chk("R11 prescaler cleared", rv, 0);
        wr(4'd0, 32'h9);
        idle(33);
        wr(4'd0, 32'h8);
        rd(4'd11, rv); chk("R11 tick at 64", rv, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule